// File: doc/BRIEF.md
# Banked Read Conflict Estimator

This block measures how much a single vector of scratchpad reads is slowed by bank conflicts. A vector arrives as a stream of entries, one per clock. Each entry carries a line address and a column address. The block works out which bank each column falls into and keeps a record of the distinct lines that each bank has to open. When the vector ends, it divides each bank's distinct-line count by the number of ports per bank and reports the worst bank as the vector's service time. It also reports the extra stall, which is the service time beyond one cycle.

The bank count, the ports per bank and the total column bandwidth are runtime inputs. The block samples them with the first entry of each vector and holds them until that vector ends, so a controller can change the topology between vectors without disturbing one that is in flight. A performance model or an arbitration unit can use the result to charge conflict cycles to a read stream.

Top module: `bank_conflict_est`

## Requirements
- R1: Bank width is max(1, ceil(bandwidth / effective_bank_count)).
- R2: The bank index is column / bank_width. When that value exceeds effective_bank_count - 1, it is clamped to effective_bank_count - 1.
- R3: A bank counts each distinct line address at most once per vector. A line that repeats on the same bank adds nothing.
- R4: An entry whose line address is all ones (the -1 code) is invalid. It is not counted, but its first and last flags still take effect.
- R5: A bank-count input of 0 is treated as 1, and a value above MAX_BANKS is treated as MAX_BANKS. A port-count input of 0 is treated as 1.
- R6: The service result is the maximum over all banks of ceil(count / ports), and it is 0 when no entry in the vector was valid. The stall is the service result minus 1, or 0 when the service result is 0.
- R7: Bank count, port count and bandwidth are taken from the entry that has req_first set. The values on those inputs during later entries of the same vector have no effect.
- R8: done_o is high for exactly one cycle, two rising edges after the edge that accepts an entry with req_last set. A new vector may begin in the very next cycle. svc_o and stall_o hold their values until the next done_o.
- R9: Each bank stores up to CAM_DEPTH distinct lines. Once that store is full, a line that matches no stored entry is counted again, which overestimates conservatively. The count saturates at its maximum value.
- R10: Reset clears done_o, svc_o and stall_o to 0 and discards any vector in progress.
- R11: A cycle with req_valid low neither adds an entry nor ends the vector. While no vector is open, an entry without req_first is ignored, including its req_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_banks | input | BCFG_W | Requested bank count, sampled with the first entry |
| cfg_ports | input | PORT_W | Ports per bank, sampled with the first entry |
| cfg_bw | input | BW_W | Total column bandwidth, sampled with the first entry |
| req_valid | input | 1 | An entry is present this cycle |
| req_first | input | 1 | The entry opens a vector |
| req_last | input | 1 | The entry closes a vector |
| req_line | input | LINE_W | Line address; all ones marks an invalid entry |
| req_col | input | COL_W | Column address |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| svc_o | output | CNT_W | Worst-bank service cycles |
| stall_o | output | CNT_W | Extra conflict cycles |

## Verification
The bench builds the block with MAX_BANKS of 4 and CAM_DEPTH of 4. With these values, a bank-count request of 7 exercises the upper clamp, and a single bank receiving five distinct lines fills its store, so the conservative overflow count shows up in a short vector. A bandwidth of 8 over 3 banks makes the bank width non-divisible, which places a high column index beyond the last bank and exercises the index clamp. The table runs vectors back to back with no gap, so a result pulse always coincides with the start of the next vector.

// File: rtl/bce_pkg.sv
package bce_pkg;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } phase_e;

    // Ceiling division; a zero divisor is treated as one.
    function automatic logic [31:0] div_up(input logic [31:0] num, input logic [31:0] den);
        logic [31:0] d;
        d = (den == 32'd0) ? 32'd1 : den;
        return (num + d - 32'd1) / d;
    endfunction

endpackage

// File: rtl/bce_bank_map.sv
module bce_bank_map #(
    parameter int BCFG_W = 4,
    parameter int BW_W   = 7,
    parameter int COL_W  = 6,
    parameter int BIDX_W = 3
) (
    input  logic [BCFG_W-1:0] banks,
    input  logic [BW_W-1:0]   bw,
    input  logic [COL_W-1:0]  col,
    output logic [BIDX_W-1:0] bank_idx
);
    import bce_pkg::*;

    logic [31:0] width;
    logic [31:0] raw_idx;
    logic [31:0] top_idx;

    always_comb begin
        width = div_up(32'(bw), 32'(banks));
        if (width == 32'd0) width = 32'd1;
        raw_idx = 32'(col) / width;
        top_idx = 32'(banks) - 32'd1;
        if (raw_idx > top_idx) raw_idx = top_idx;
        bank_idx = BIDX_W'(raw_idx);
    end

endmodule

// File: rtl/bce_line_cam.sv
module bce_line_cam #(
    parameter int DEPTH  = 8,
    parameter int LINE_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sel,
    input  logic [LINE_W-1:0] line,
    output logic [CNT_W-1:0]  count
);
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LINE_W-1:0] tag_q [DEPTH];
    logic [DEPTH-1:0]  used_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  match;
    logic              hit;
    logic              free_found;
    logic [SLOT_W-1:0] free_slot;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            match[i] = used_q[i] && (tag_q[i] == line);
        end
        hit = (|match) && !clear;
    end

    always_comb begin
        free_found = 1'b0;
        free_slot  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!free_found && !used_q[i]) begin
                free_found = 1'b1;
                free_slot  = SLOT_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            used_q <= sel ? DEPTH'(1) : '0;
            cnt_q  <= sel ? CNT_W'(1) : '0;
        end else if (sel && !hit) begin
            if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
            if (free_found) used_q[free_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clear && sel) begin
            tag_q[0] <= line;
        end else if (sel && !hit && free_found) begin
            tag_q[free_slot] <= line;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/bce_reduce.sv
module bce_reduce #(
    parameter int NB     = 8,
    parameter int CNT_W  = 5,
    parameter int PORT_W = 3
) (
    input  logic [CNT_W-1:0]  counts [NB],
    input  logic [PORT_W-1:0] ports,
    output logic [CNT_W-1:0]  svc
);
    import bce_pkg::*;

    logic [31:0] best;
    logic [31:0] need;

    always_comb begin
        best = 32'd0;
        need = 32'd0;
        for (int b = 0; b < NB; b++) begin
            need = div_up(32'(counts[b]), 32'(ports));
            if (need > best) best = need;
        end
        svc = CNT_W'(best);
    end

endmodule

// File: rtl/bank_conflict_est.sv
module bank_conflict_est #(
    parameter int MAX_BANKS = 8,
    parameter int CAM_DEPTH = 8,
    parameter int LINE_W    = 8,
    parameter int COL_W     = 6,
    parameter int BW_W      = 7,
    parameter int PORT_W    = 3,
    parameter int CNT_W     = 5,
    parameter int BCFG_W    = $clog2(MAX_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BCFG_W-1:0] cfg_banks,
    input  logic [PORT_W-1:0] cfg_ports,
    input  logic [BW_W-1:0]   cfg_bw,
    input  logic              req_valid,
    input  logic              req_first,
    input  logic              req_last,
    input  logic [LINE_W-1:0] req_line,
    input  logic [COL_W-1:0]  req_col,
    output logic              done_o,
    output logic [CNT_W-1:0]  svc_o,
    output logic [CNT_W-1:0]  stall_o
);
    import bce_pkg::*;

    localparam int BIDX_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1;

    typedef struct packed {
        logic [BCFG_W-1:0] banks;
        logic [PORT_W-1:0] ports;
        logic [BW_W-1:0]   bw;
    } topo_t;

    phase_e            phase_q;
    topo_t             topo_q;
    topo_t             topo_in;
    topo_t             topo_now;
    logic              acc;
    logic              acc_first;
    logic              acc_last;
    logic              line_ok;
    logic              fin_q;
    logic [BIDX_W-1:0] bank_idx;
    logic [CNT_W-1:0]  bank_cnt [MAX_BANKS];
    logic [CNT_W-1:0]  svc_now;

    assign acc_first = req_valid && req_first;
    assign acc       = req_valid && (req_first || (phase_q == PH_ACTIVE));
    assign acc_last  = acc && req_last;
    assign line_ok   = (req_line != '1);

    always_comb begin
        if (cfg_banks == '0)
            topo_in.banks = BCFG_W'(1);
        else if (int'(cfg_banks) > MAX_BANKS)
            topo_in.banks = BCFG_W'(MAX_BANKS);
        else
            topo_in.banks = cfg_banks;
        topo_in.ports = (cfg_ports == '0) ? PORT_W'(1) : cfg_ports;
        topo_in.bw    = cfg_bw;
        topo_now      = acc_first ? topo_in : topo_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            topo_q.banks <= BCFG_W'(1);
            topo_q.ports <= PORT_W'(1);
            topo_q.bw    <= '0;
            fin_q        <= 1'b0;
        end else begin
            if (acc_first) topo_q <= topo_in;
            if (acc_last)
                phase_q <= PH_IDLE;
            else if (acc_first)
                phase_q <= PH_ACTIVE;
            fin_q <= acc_last;
        end
    end

    bce_bank_map #(
        .BCFG_W (BCFG_W),
        .BW_W   (BW_W),
        .COL_W  (COL_W),
        .BIDX_W (BIDX_W)
    ) map_i (
        .banks    (topo_now.banks),
        .bw       (topo_now.bw),
        .col      (req_col),
        .bank_idx (bank_idx)
    );

    for (genvar g = 0; g < MAX_BANKS; g++) begin : g_bank
        logic hit_bank;
        assign hit_bank = acc && line_ok && (bank_idx == BIDX_W'(g));
        bce_line_cam #(
            .DEPTH  (CAM_DEPTH),
            .LINE_W (LINE_W),
            .CNT_W  (CNT_W)
        ) cam_i (
            .clk   (clk),
            .rst   (rst),
            .clear (acc_first),
            .sel   (hit_bank),
            .line  (req_line),
            .count (bank_cnt[g])
        );
    end

    bce_reduce #(
        .NB     (MAX_BANKS),
        .CNT_W  (CNT_W),
        .PORT_W (PORT_W)
    ) red_i (
        .counts (bank_cnt),
        .ports  (topo_q.ports),
        .svc    (svc_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o  <= 1'b0;
            svc_o   <= '0;
            stall_o <= '0;
        end else begin
            done_o <= fin_q;
            if (fin_q) begin
                svc_o   <= svc_now;
                stall_o <= (svc_now == '0) ? '0 : svc_now - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
    parameter int CNT_W  = 5,
    parameter int BIDX_W = 3,
    parameter int BCFG_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              acc,
    input logic              acc_last,
    input logic [BIDX_W-1:0] bank_idx,
    input logic [BCFG_W-1:0] banks_now,
    input logic              done_o,
    input logic [CNT_W-1:0]  svc_o,
    input logic [CNT_W-1:0]  stall_o
);

    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
        acc_last |=> ##1 done_o); // R8

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(acc_last, 2)); // R8

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(svc_o) && $stable(stall_o))); // R8

    AST_STALL_MATCHES: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((svc_o == '0) ? (stall_o == '0) : (stall_o == svc_o - CNT_W'(1)))); // R6

    AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        acc |-> (32'(bank_idx) < 32'(banks_now))); // R2

endmodule

bind bank_conflict_est bce_checker #(
    .CNT_W  (CNT_W),
    .BIDX_W (BIDX_W),
    .BCFG_W (BCFG_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .acc_last  (acc_last),
    .bank_idx  (bank_idx),
    .banks_now (topo_now.banks),
    .done_o    (done_o),
    .svc_o     (svc_o),
    .stall_o   (stall_o)
);

// File: tb/bank_conflict_est_tb_top.sv
module bank_conflict_est_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB   = 4;
    localparam int DEPTH  = 4;
    localparam int LW     = 8;
    localparam int CW     = 6;
    localparam int BWW    = 7;
    localparam int PW     = 3;
    localparam int NW     = 5;
    localparam int BCW    = 3;
    localparam int NROWS  = 37;
    localparam int NVEC   = 9;

    typedef struct packed {
        logic           v;
        logic           f;
        logic           l;
        logic [BCW-1:0] banks;
        logic [PW-1:0]  ports;
        logic [BWW-1:0] bw;
        logic [LW-1:0]  line;
        logic [CW-1:0]  col;
        logic [NW-1:0]  exp_svc;
    } row_t;

    // v, first, last, banks, ports, bw, line, col, expected service (on last rows)
    localparam row_t TBL [NROWS] = '{
        // vec0 R3: width 4, bank0 sees lines 1,1,3 -> 2 ports 1
        '{1'b1,1'b1,1'b0,3'd2,3'd1,7'd8, 8'd1, 6'd0, 5'd0},
        '{1'b1,1'b0,1'b0,3'd2,3'd1,7'd8, 8'd1, 6'd1, 5'd0},
        '{1'b1,1'b0,1'b0,3'd2,3'd1,7'd8, 8'd2, 6'd5, 5'd0},
        '{1'b1,1'b0,1'b1,3'd2,3'd1,7'd8, 8'd3, 6'd2, 5'd2},
        // vec1 R1 R2: width ceil(8/3)=3, col 63 clamps to bank 2
        '{1'b1,1'b1,1'b0,3'd3,3'd2,7'd8, 8'd10,6'd7, 5'd0},
        '{1'b1,1'b0,1'b0,3'd3,3'd2,7'd8, 8'd11,6'd8, 5'd0},
        '{1'b1,1'b0,1'b0,3'd3,3'd2,7'd8, 8'd12,6'd63,5'd0},
        '{1'b1,1'b0,1'b1,3'd3,3'd2,7'd8, 8'd13,6'd0, 5'd2},
        // vec2 R4: all invalid
        '{1'b1,1'b1,1'b0,3'd2,3'd1,7'd8, 8'hFF,6'd0, 5'd0},
        '{1'b1,1'b0,1'b1,3'd2,3'd1,7'd8, 8'hFF,6'd3, 5'd0},
        // vec3 R5 R1: zero config -> one bank, one port, width 1
        '{1'b1,1'b1,1'b0,3'd0,3'd0,7'd0, 8'd1, 6'd0, 5'd0},
        '{1'b1,1'b0,1'b0,3'd0,3'd0,7'd0, 8'd2, 6'd9, 5'd0},
        '{1'b1,1'b0,1'b1,3'd0,3'd0,7'd0, 8'd1, 6'd20,5'd2},
        // vec4 R9: store of 4 fills, line 5 counted twice
        '{1'b1,1'b1,1'b0,3'd1,3'd1,7'd4, 8'd1, 6'd0, 5'd0},
        '{1'b1,1'b0,1'b0,3'd1,3'd1,7'd4, 8'd2, 6'd0, 5'd0},
        '{1'b1,1'b0,1'b0,3'd1,3'd1,7'd4, 8'd3, 6'd0, 5'd0},
        '{1'b1,1'b0,1'b0,3'd1,3'd1,7'd4, 8'd4, 6'd0, 5'd0},
        '{1'b1,1'b0,1'b0,3'd1,3'd1,7'd4, 8'd5, 6'd0, 5'd0},
        '{1'b1,1'b0,1'b1,3'd1,3'd1,7'd4, 8'd5, 6'd0, 5'd6},
        // vec5 R7: config changes after the first entry are ignored
        '{1'b1,1'b1,1'b0,3'd4,3'd1,7'd8, 8'd1, 6'd0, 5'd0},
        '{1'b1,1'b0,1'b0,3'd1,3'd1,7'd1, 8'd2, 6'd2, 5'd0},
        '{1'b1,1'b0,1'b0,3'd1,3'd1,7'd1, 8'd3, 6'd4, 5'd0},
        '{1'b1,1'b0,1'b1,3'd1,3'd1,7'd1, 8'd4, 6'd6, 5'd1},
        // vec6 R6: single entry vector, 3 ports
        '{1'b1,1'b1,1'b1,3'd2,3'd3,7'd2, 8'd7, 6'd1, 5'd1},
        // vec7 R3 R11: idle cycle mid-vector, repeated line 1
        '{1'b1,1'b1,1'b0,3'd2,3'd2,7'd4, 8'd1, 6'd0, 5'd0},
        '{1'b0,1'b0,1'b0,3'd0,3'd0,7'd0, 8'd0, 6'd0, 5'd0},
        '{1'b1,1'b0,1'b0,3'd2,3'd2,7'd4, 8'd2, 6'd1, 5'd0},
        '{1'b1,1'b0,1'b0,3'd2,3'd2,7'd4, 8'd3, 6'd0, 5'd0},
        '{1'b1,1'b0,1'b0,3'd2,3'd2,7'd4, 8'd4, 6'd1, 5'd0},
        '{1'b1,1'b0,1'b0,3'd2,3'd2,7'd4, 8'd1, 6'd1, 5'd0},
        '{1'b1,1'b0,1'b1,3'd2,3'd2,7'd4, 8'd9, 6'd2, 5'd2},
        // vec8 R5 R2: bank request 7 clamps to 4, col 14 clamps to bank 3
        '{1'b1,1'b1,1'b0,3'd7,3'd1,7'd8, 8'd1, 6'd6, 5'd0},
        '{1'b1,1'b0,1'b0,3'd7,3'd1,7'd8, 8'd2, 6'd7, 5'd0},
        '{1'b1,1'b0,1'b1,3'd7,3'd1,7'd8, 8'd3, 6'd14,5'd3},
        // trailing idle rows
        '{1'b0,1'b0,1'b0,3'd0,3'd0,7'd0, 8'd0, 6'd0, 5'd0},
        '{1'b0,1'b0,1'b0,3'd0,3'd0,7'd0, 8'd0, 6'd0, 5'd0},
        '{1'b0,1'b0,1'b0,3'd0,3'd0,7'd0, 8'd0, 6'd0, 5'd0}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [BCW-1:0] cfg_banks = '0;
    logic [PW-1:0]  cfg_ports = '0;
    logic [BWW-1:0] cfg_bw = '0;
    logic           req_valid = 1'b0;
    logic           req_first = 1'b0;
    logic           req_last = 1'b0;
    logic [LW-1:0]  req_line = '0;
    logic [CW-1:0]  req_col = '0;
    logic           done_o;
    logic [NW-1:0]  svc_o;
    logic [NW-1:0]  stall_o;

    int n_checks = 0;
    int n_fail = 0;
    int n_done = 0;
    int wr_idx = 0;
    int rd_idx = 0;
    bit summary_done = 1'b0;
    logic [NW-1:0] exp_q [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_conflict_est #(
        .MAX_BANKS (MAXB),
        .CAM_DEPTH (DEPTH),
        .LINE_W    (LW),
        .COL_W     (CW),
        .BW_W      (BWW),
        .PORT_W    (PW),
        .CNT_W     (NW),
        .BCFG_W    (BCW)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_banks (cfg_banks),
        .cfg_ports (cfg_ports),
        .cfg_bw    (cfg_bw),
        .req_valid (req_valid),
        .req_first (req_first),
        .req_last  (req_last),
        .req_line  (req_line),
        .req_col   (req_col),
        .done_o    (done_o),
        .svc_o     (svc_o),
        .stall_o   (stall_o)
    );

    function automatic string vec_tag(input int v);
        case (v)
            0: return "R3";
            1: return "R1 R2";
            2: return "R4";
            3: return "R5 R1";
            4: return "R9";
            5: return "R7";
            6: return "R6";
            7: return "R3 R11";
            8: return "R5 R2";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_row(input row_t r);
        cfg_banks = r.banks;
        cfg_ports = r.ports;
        cfg_bw    = r.bw;
        req_valid = r.v;
        req_first = r.f;
        req_last  = r.l;
        req_line  = r.line;
        req_col   = r.col;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        req_first = 1'b0;
        req_last  = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Result monitor: R6 R8 (back-to-back vectors; one result per closed vector)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done_o) begin
                n_done++;
                if (rd_idx >= wr_idx) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    logic [NW-1:0] es;
                    logic [NW-1:0] est;
                    es  = exp_q[rd_idx];
                    est = (es == '0) ? '0 : es - NW'(1);
                    check(svc_o == es, $sformatf("R6 %s svc vec%0d", vec_tag(rd_idx), rd_idx),
                          int'(svc_o), int'(es));
                    check(stall_o == est, $sformatf("R6 stall vec%0d", rd_idx),
                          int'(stall_o), int'(est));
                    rd_idx++;
                end
            end
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        if (!summary_done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary_done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(done_o == 1'b0, "R10 done after reset", int'(done_o), 0);
        check(svc_o == '0 && stall_o == '0, "R10 outputs after reset", int'(svc_o), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NROWS; i++) begin
            put_row(TBL[i]);
            if (TBL[i].v && TBL[i].l) begin
                exp_q[wr_idx] = TBL[i].exp_svc;
                wr_idx++;
            end
            @(negedge clk);
        end
        idle(4);
        check(n_done == NVEC, "R8 result count", n_done, NVEC);
        // R8: result holds while no new vector closes
        check(svc_o == NW'(3), "R8 svc held", int'(svc_o), 3);

        // R11 / R7: stray entry with last but no open vector is ignored
        base = n_done;
        put_row('{1'b1,1'b0,1'b1,3'd2,3'd1,7'd8,8'd1,6'd0,5'd0});
        @(negedge clk);
        idle(4);
        check(n_done == base, "R11 stray last ignored", n_done, base);
        check(svc_o == NW'(3), "R11 svc unchanged by stray", int'(svc_o), 3);

        // R10: reset during an open vector discards it
        put_row('{1'b1,1'b1,1'b0,3'd1,3'd1,7'd4,8'd1,6'd0,5'd0});
        @(negedge clk);
        idle(0);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(svc_o == '0 && stall_o == '0 && done_o == 1'b0, "R10 reset clears result",
              int'(svc_o), 0);
        rst = 1'b0;
        base = n_done;
        put_row('{1'b1,1'b0,1'b1,3'd1,3'd1,7'd4,8'd2,6'd0,5'd0});
        @(negedge clk);
        idle(4);
        check(n_done == base, "R10 vector discarded by reset", n_done, base);

        summary_done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule